// File: doc/BRIEF.md
# Sequentiality-Controlled Address Stream Generator

This block produces a stream of address words that imitates the memory accesses of a running program. Each enabled clock cycle it emits one address. The address either continues a running sequential counter, as a loop walking through memory would, or jumps to a pseudo-random address spread uniformly over the range from 0 to a programmable upper limit, as a taken branch would. An 8-bit fraction sets the probability that a step is sequential, and the jump weight is its complement.

The random source is a 32-bit maximal-length shift register that is loaded from a seed input at reset. One byte of its state decides between the two paths. A separate 16-bit field supplies the jump target, which is reduced into range by an unrolled restoring remainder. After a jump, counting resumes from the jump target, so the next sequential address is the target plus one. The counter wraps to 0 once it reaches the upper limit. The stream is intended to drive codec and bus-activity experiments, which lie outside this block.

Top module: `addr_stream_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `addr_valid` becomes 0, `addr_out` becomes 0 and the sequential counter becomes 0.
- R2: `addr_valid` after each edge equals `en` at that edge. A cycle with `en` low leaves `addr_out`, the counter and the random state unchanged.
- R3: At reset the 32-bit random state S loads `seed`, or 1 when `seed` is 0. Each enabled cycle it becomes {S[30:0], S[31]^S[21]^S[1]^S[0]}. The step uses S from before this update, so S never becomes 0.
- R4: A step is sequential when the byte S[31:24] is less than `seq_frac`, compared as unsigned. With `seq_frac` = 0 no step is sequential.
- R5: A sequential step emits the counter value, or 0 if the counter exceeds `max_addr`. The first sequential address after reset is 0.
- R6: A jump step emits S[15:0] modulo (`max_addr` + 1).
- R7: After each enabled step the counter holds the emitted address plus 1, or 0 when the emitted address is greater than or equal to `max_addr`.
- R8: Every address shown with `addr_valid` high is at most the `max_addr` applied at the producing edge.
- R9: Over 4000 consecutive enabled steps with `max_addr` = 65535, the share of outputs equal to the previous output plus 1 lies within 0.05 of `seq_frac`/256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Produce one address this cycle |
| seq_frac | input | 8 | Probability of a sequential step, in units of 1/256 |
| max_addr | input | 16 | Largest address that may be emitted |
| seed | input | 32 | Random state loaded at reset |
| addr_out | output | 16 | Registered address |
| addr_valid | output | 1 | High for the cycle after an enabled edge |

## Verification
Every result of this block appears in the registered outputs one edge after the enabled cycle that produced it. There is no further pipeline, because the range reduction is combinational within the step. The reference model in the bench advances its state on the same rising edge, using the inputs held stable since the previous falling edge. The bench compares `addr_out` and `addr_valid` at the following falling edge on every cycle, including idle and reset cycles. The share measurement counts successive outputs from those same samples.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic {PICK_JUMP = 1'b0, PICK_SEQ = 1'b1} pick_e;
  localparam logic [31:0] LFSR32_TAPS  = 32'h8020_0003;
  localparam logic [31:0] LFSR_NONZERO = 32'h0000_0001;
endpackage

// File: rtl/agen_lfsr.sv
module agen_lfsr #(
  parameter int W = 32,
  parameter logic [W-1:0] TAPS = agen_pkg::LFSR32_TAPS,
  parameter logic [W-1:0] FALLBACK = agen_pkg::LFSR_NONZERO
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= (seed == '0) ? FALLBACK : seed;
    end else if (step) begin
      state <= {state[W-2:0], fb};
    end
  end
endmodule

// File: rtl/agen_mod_reduce.sv
module agen_mod_reduce #(
  parameter int W = 16
) (
  input  logic [W-1:0] value,
  input  logic [W:0]   modulus,
  output logic [W-1:0] remainder
);
  logic [W-1:0] rem [0:W];
  assign rem[0] = '0;

  for (genvar k = 0; k < W; k++) begin : g_stage
    logic [W:0]   trial;
    logic [W-1:0] diff;
    assign trial = {rem[k], value[W-1-k]};
    assign diff  = trial[W-1:0] - modulus[W-1:0];
    assign rem[k+1] = (trial >= modulus) ? diff : trial[W-1:0];
  end

  assign remainder = rem[W];
endmodule

// File: rtl/addr_stream_gen.sv
module addr_stream_gen #(
  parameter int ADDR_W = 16,
  parameter int FRAC_W = 8,
  parameter int LFSR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [FRAC_W-1:0] seq_frac,
  input  logic [ADDR_W-1:0] max_addr,
  input  logic [LFSR_W-1:0] seed,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_valid
);
  import agen_pkg::*;

  localparam int MID_LO = ADDR_W;
  localparam int MID_HI = LFSR_W - FRAC_W - 1;

  logic [LFSR_W-1:0] lfsr_q;
  logic [FRAC_W-1:0] pick_byte;
  logic [ADDR_W-1:0] raw_addr;
  logic [ADDR_W:0]   span;
  logic [ADDR_W-1:0] jump_addr;
  logic [ADDR_W-1:0] seq_cnt;
  logic [ADDR_W-1:0] seq_addr;
  logic [ADDR_W-1:0] next_addr;
  pick_e             pick;

  agen_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk  (clk),
    .rst  (rst),
    .step (en),
    .seed (seed),
    .state(lfsr_q)
  );

  assign pick_byte = lfsr_q[LFSR_W-1 -: FRAC_W];
  assign raw_addr  = lfsr_q[ADDR_W-1:0];

  if (MID_HI >= MID_LO) begin : g_mid
    logic unused_mid;
    assign unused_mid = ^lfsr_q[MID_HI:MID_LO];
  end

  assign span = (ADDR_W+1)'(max_addr) + (ADDR_W+1)'(1);

  agen_mod_reduce #(.W(ADDR_W)) u_mod (
    .value    (raw_addr),
    .modulus  (span),
    .remainder(jump_addr)
  );

  always_comb begin
    pick      = (pick_byte < seq_frac) ? PICK_SEQ : PICK_JUMP;
    seq_addr  = (seq_cnt > max_addr) ? '0 : seq_cnt;
    next_addr = (pick == PICK_SEQ) ? seq_addr : jump_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_cnt    <= '0;
      addr_out   <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= en;
      if (en) begin
        addr_out <= next_addr;
        seq_cnt  <= (next_addr >= max_addr) ? '0 : next_addr + ADDR_W'(1);
      end
    end
  end
endmodule

// File: rtl/agen_checker.sv
module agen_checker #(
  parameter int ADDR_W = 16,
  parameter int LFSR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [ADDR_W-1:0] max_addr,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_valid,
  input logic [LFSR_W-1:0] lfsr_state
);
  assert_valid_follows_en_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (addr_valid == $past(en)));

  assert_idle_holds_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> $stable(addr_out));

  assert_state_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    lfsr_state != '0);

  assert_idle_holds_state_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> $stable(lfsr_state));

  assert_addr_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    (addr_valid && !$past(rst)) |-> (addr_out <= $past(max_addr)));
endmodule

bind addr_stream_gen agen_checker #(.ADDR_W(ADDR_W), .LFSR_W(LFSR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .max_addr  (max_addr),
  .addr_out  (addr_out),
  .addr_valid(addr_valid),
  .lfsr_state(lfsr_q)
);

// File: tb/tb_addr_stream_gen.sv
module tb_addr_stream_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [7:0]  seq_frac = 8'd0;
  logic [15:0] max_addr = 16'hFFFF;
  logic [31:0] seed = 32'h1234_5678;
  logic [15:0] addr_out;
  logic        addr_valid;

  int total = 0;
  int bad = 0;

  addr_stream_gen dut (
    .clk(clk), .rst(rst), .en(en), .seq_frac(seq_frac),
    .max_addr(max_addr), .seed(seed),
    .addr_out(addr_out), .addr_valid(addr_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model
  bit [31:0] ms;
  int        mcnt;
  int        eaddr;
  bit        evalid;
  int        emax;

  always @(posedge clk) begin
    if (rst) begin
      ms = (seed == 0) ? 32'd1 : seed;
      mcnt = 0; eaddr = 0; evalid = 0;
    end else begin
      evalid = en;
      if (en) begin
        if (int'(ms[31:24]) < int'(seq_frac)) eaddr = (mcnt > int'(max_addr)) ? 0 : mcnt;
        else eaddr = int'(ms[15:0]) % (int'(max_addr) + 1);
        mcnt = (eaddr >= int'(max_addr)) ? 0 : eaddr + 1;
        ms = {ms[30:0], ms[31] ^ ms[21] ^ ms[1] ^ ms[0]};
        emax = int'(max_addr);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison and share measurement
  bit compare_on = 0;
  bit share_on = 0;
  int share_steps = 0;
  int share_seq = 0;
  bit prev_v = 0;
  int prev_a = 0;

  always @(negedge clk) begin
    if (compare_on) begin
      chk(addr_valid == evalid, "R2 valid", int'(addr_valid), int'(evalid));
      chk(int'(addr_out) == eaddr, "R3/R4/R5/R6/R7 addr", int'(addr_out), eaddr);
      if (addr_valid && evalid)
        chk(int'(addr_out) <= emax, "R8 range", int'(addr_out), emax);
    end
    if (share_on && addr_valid) begin
      share_steps++;
      if (prev_v && int'(addr_out) == prev_a + 1) share_seq++;
    end
    prev_v = addr_valid;
    prev_a = int'(addr_out);
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [31:0] s);
    @(negedge clk);
    seed = s; rst = 1'b1; en = 1'b0;
    run(3);
    rst = 1'b0;
  endtask

  task automatic measure_share(input logic [7:0] f);
    int lo_pm, hi_pm, got_pm;
    seq_frac = f; max_addr = 16'hFFFF; en = 1'b1;
    run(2);
    share_steps = 0; share_seq = 0; share_on = 1;
    run(4000);
    share_on = 0;
    got_pm = (share_seq * 1000) / share_steps;
    lo_pm = (int'(f) * 1000) / 256 - 50;
    hi_pm = (int'(f) * 1000) / 256 + 50;
    chk(got_pm >= lo_pm && got_pm <= hi_pm, "R9 share per mille", got_pm, (int'(f) * 1000) / 256);
  endtask

  initial begin
    run(3);
    // R1 reset state
    chk(addr_valid == 1'b0, "R1 valid in reset", int'(addr_valid), 0);
    chk(addr_out == 16'd0, "R1 addr in reset", int'(addr_out), 0);
    compare_on = 1;
    rst = 1'b0;

    // R5 R7 mostly sequential, wrap at small limit
    seq_frac = 8'd255; max_addr = 16'd9; en = 1'b1;
    run(1);
    chk(addr_valid == 1'b1, "R2 valid after enable", int'(addr_valid), 1);
    chk(addr_out == 16'd0, "R5 first sequential address", int'(addr_out), 0);
    run(40);

    // R2 idle gaps with mixed choices and non power-of-two limit
    seq_frac = 8'd128; max_addr = 16'd1000;
    for (int i = 0; i < 60; i++) begin
      en = (i % 3) != 0;
      run(1);
    end
    en = 1'b0;
    run(5);

    // R4 R6 never sequential, power-of-two span
    seq_frac = 8'd0; max_addr = 16'd255; en = 1'b1;
    run(60);

    // R5 limit lowered below counter, then a single-address range
    seq_frac = 8'd255; max_addr = 16'd40000;
    run(30);
    max_addr = 16'd3;
    run(20);
    max_addr = 16'd0;
    run(20);

    // R1 R3 reset with zero seed
    do_reset(32'd0);
    chk(addr_valid == 1'b0, "R1 valid after reset", int'(addr_valid), 0);
    seq_frac = 8'd100; max_addr = 16'd777; en = 1'b1;
    run(60);

    // R9 long-run share
    do_reset(32'hC0FF_EE01);
    measure_share(8'd128);
    measure_share(8'd64);
    measure_share(8'd200);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule